// File: doc/BRIEF.md
# Integer to Single-Precision Converter

This block turns a 32-bit integer, read either as two's complement or as unsigned, into an IEEE-754 binary32 value that is correctly rounded. The rounding direction comes from a 3-bit static field that travels with the operand. One code of that field defers to a 3-bit dynamic mode value, which is also supplied with the operand. Before any result is formed, the field is decoded for legality. A reserved static code, or a reserved dynamic code reached through the deferral, yields an illegal-operation indication in place of a result. This happens even when the operand is zero, where rounding could not change the value.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. One register stage sits between them. An operand transfers on a cycle where `in_valid` and `in_ready` are both high, and its result appears on the following cycle. A result transfers on a cycle where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the block holds the whole output payload steady and drops `in_ready`, so back-pressure reaches the producer in the same cycle. Exceptions never trap. Each result carries inexact and invalid flag bits that the consumer ORs into its accrued flags. Invalid can never arise in this conversion.

Top module: `i2f_conv`

## Requirements
- R1: An operand is accepted when `in_valid && in_ready`, and its result is presented with `out_valid` high on the next cycle. `in_ready` is low only while `out_valid` is high and `out_ready` is low.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bits`, `out_illegal`, `out_nx` and `out_nv` keep their values.
- R3: Rounding codes are 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity and 100 nearest with ties away from zero. Code 111 in `in_rm` applies the mode given by `in_frm`.
- R4: A static `in_rm` of 101 or 110 gives `out_illegal`=1, `out_bits`=0 and both flags 0, whatever the operand, including zero.
- R5: `in_rm`=111 with `in_frm` of 101, 110 or 111 gives `out_illegal`=1, `out_bits`=0 and both flags 0.
- R6: With `in_signed`=1, the operand is read as two's complement and a negative value sets sign bit 31. With `in_signed`=0, the sign bit is always 0.
- R7: A legal result is the operand rounded under the selected mode into binary32: sign in bit 31, exponent in bits 30:23 with bias 127, fraction in bits 22:0. Carry from rounding moves the value to the next exponent.
- R8: A zero operand gives 0x00000000 with both flags 0 in every legal mode.
- R9: `out_nx` is 1 exactly when a legal rounded result differs from the operand. `out_nv` is always 0.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Block can take an operand |
| in_int | input | 32 | Integer operand |
| in_signed | input | 1 | 1: two's complement, 0: unsigned |
| in_rm | input | 3 | Static rounding field (111 defers to in_frm) |
| in_frm | input | 3 | Dynamic rounding mode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_bits | output | 32 | binary32 result |
| out_illegal | output | 1 | Reserved rounding encoding seen |
| out_nx | output | 1 | Inexact flag |
| out_nv | output | 1 | Invalid flag (always 0) |

## Verification
The checker watches the stream protocol on every cycle. It checks that acceptance leads to a result on the next cycle, that ready falls only under stall, and that the payload holds while stalled. It also checks that an illegal result is quiet zero, that invalid never rises, and that a zero result is never inexact. The numeric value of each rounded result, the choice between static and deferred modes, and the legality decode per encoding can only be shown by the bench scenarios. These compare against an integer-arithmetic model, with directed ties, extremes such as 0x80000000 and 0xFFFFFFFF, and reserved codes applied to zero operands.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

  // Resolved rounding direction; code values are the field encodings.
  typedef enum logic [2:0] {
    RND_NE = 3'd0,  // nearest, ties to even
    RND_TZ = 3'd1,  // toward zero
    RND_DN = 3'd2,  // toward minus infinity
    RND_UP = 3'd3,  // toward plus infinity
    RND_NM = 3'd4   // nearest, ties away from zero
  } rnd_mode_e;

  localparam logic [2:0] RM_DEFER = 3'b111;

  typedef struct packed {
    logic nv;
    logic nx;
  } exc_flags_t;

endpackage

// File: rtl/i2f_rm_decode.sv
module i2f_rm_decode
  import i2f_pkg::*;
(
  input  logic [2:0] rm,
  input  logic [2:0] frm,
  output rnd_mode_e  mode,
  output logic       illegal
);

  logic [2:0] sel;
  logic       static_bad;
  logic       dyn_bad;

  always_comb begin
    static_bad = (rm == 3'b101) || (rm == 3'b110);
    dyn_bad    = (rm == RM_DEFER) && (frm > 3'b100);
    illegal    = static_bad || dyn_bad;
    sel        = (rm == RM_DEFER) ? frm : rm;
    mode       = illegal ? RND_NE : rnd_mode_e'(sel);
  end

endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize #(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [INT_W-1:0] op,
  input  logic             is_signed,
  output logic             neg,
  output logic             is_zero,
  output logic [EXP_W-1:0] exp,
  output logic [MAN_W-1:0] frac,
  output logic             guard,
  output logic             sticky
);

  localparam int LZ_W    = $clog2(INT_W);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int TOP_EXP = BIAS + INT_W - 1;
  localparam int G_POS   = INT_W - MAN_W - 2;

  logic [INT_W-1:0] mag;
  logic [LZ_W-1:0]  lz;
  logic [INT_W-1:0] stage [LZ_W+1];
  logic [INT_W-1:0] norm;

  assign neg = is_signed & op[INT_W-1];
  assign mag = neg ? (~op + INT_W'(1)) : op;

  // Leading-zero count: the highest set bit wins.
  always_comb begin
    lz = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lz = LZ_W'(INT_W - 1 - i);
    end
  end

  // Logarithmic left shifter, one stage per count bit.
  assign stage[0] = mag;
  for (genvar k = 0; k < LZ_W; k++) begin : g_shift
    assign stage[k+1] = lz[k] ? (stage[k] << (1 << k)) : stage[k];
  end
  assign norm = stage[LZ_W];

  assign is_zero = ~norm[INT_W-1];
  assign exp     = EXP_W'(TOP_EXP) - EXP_W'(lz);
  assign frac    = norm[INT_W-2 -: MAN_W];
  assign guard   = norm[G_POS];
  assign sticky  = |norm[G_POS-1:0];

endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int MAN_W = 23
) (
  input  logic [MAN_W-1:0] frac_in,
  input  logic             guard,
  input  logic             sticky,
  input  logic             neg,
  input  rnd_mode_e        mode,
  output logic [MAN_W-1:0] frac_out,
  output logic             carry,
  output logic             inexact
);

  logic         inc;
  logic         lost;
  logic [MAN_W:0] sum;

  assign lost = guard | sticky;

  always_comb begin
    unique case (mode)
      RND_NE:  inc = guard & (sticky | frac_in[0]);
      RND_TZ:  inc = 1'b0;
      RND_DN:  inc = neg & lost;
      RND_UP:  inc = ~neg & lost;
      RND_NM:  inc = guard;
      default: inc = 1'b0;
    endcase
  end

  // The hidden bit is always 1, so fraction overflow means exponent carry.
  assign sum      = {1'b0, frac_in} + (MAN_W+1)'(inc);
  assign frac_out = sum[MAN_W-1:0];
  assign carry    = sum[MAN_W];
  assign inexact  = lost;

endmodule

// File: rtl/i2f_conv.sv
module i2f_conv
  import i2f_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int OUT_W = 1 + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [INT_W-1:0] in_int,
  input  logic             in_signed,
  input  logic [2:0]       in_rm,
  input  logic [2:0]       in_frm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_bits,
  output logic             out_illegal,
  output logic             out_nx,
  output logic             out_nv
);

  rnd_mode_e        mode;
  logic             illegal;
  logic             neg;
  logic             is_zero;
  logic [EXP_W-1:0] exp_raw;
  logic [MAN_W-1:0] frac_raw;
  logic             guard;
  logic             sticky;
  logic [MAN_W-1:0] frac_rnd;
  logic             carry;
  logic             inexact;

  logic [OUT_W-1:0] bits_d, bits_q;
  exc_flags_t       flags_d, flags_q;
  logic             illegal_q;
  logic             valid_q;
  logic [EXP_W-1:0] exp_fin;

  i2f_rm_decode u_dec (
    .rm      (in_rm),
    .frm     (in_frm),
    .mode    (mode),
    .illegal (illegal)
  );

  i2f_normalize #(.INT_W(INT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .op        (in_int),
    .is_signed (in_signed),
    .neg       (neg),
    .is_zero   (is_zero),
    .exp       (exp_raw),
    .frac      (frac_raw),
    .guard     (guard),
    .sticky    (sticky)
  );

  i2f_round #(.MAN_W(MAN_W)) u_rnd (
    .frac_in  (frac_raw),
    .guard    (guard),
    .sticky   (sticky),
    .neg      (neg),
    .mode     (mode),
    .frac_out (frac_rnd),
    .carry    (carry),
    .inexact  (inexact)
  );

  always_comb begin
    exp_fin = is_zero ? '0 : (exp_raw + EXP_W'(carry));
    if (illegal) begin
      bits_d  = '0;
      flags_d = '0;
    end else begin
      bits_d     = {neg, exp_fin, frac_rnd};
      flags_d.nx = inexact;
      flags_d.nv = 1'b0;  // integer sources are always representable
    end
  end

  assign in_ready = ~valid_q | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      bits_q    <= '0;
      flags_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      if (in_ready) valid_q <= in_valid;
      if (in_valid && in_ready) begin
        bits_q    <= bits_d;
        flags_q   <= flags_d;
        illegal_q <= illegal;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_bits    = bits_q;
  assign out_illegal = illegal_q;
  assign out_nx      = flags_q.nx;
  assign out_nv      = flags_q.nv;

endmodule

// File: rtl/i2f_conv_chk.sv
module i2f_conv_chk #(
  parameter int OUT_W = 32,
  parameter int MAN_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_bits,
  input logic             out_illegal,
  input logic             out_nx,
  input logic             out_nv
);

  // R1
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1
  ready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bits)
      && $stable(out_illegal) && $stable(out_nx) && $stable(out_nv));

  // R4
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_bits == '0 && !out_nx && !out_nv);

  // R9
  no_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_nv);

  // R8
  zero_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bits == '0 |-> !out_nx);

  // R7
  finite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> !(&out_bits[OUT_W-2:MAN_W]));

endmodule

bind i2f_conv i2f_conv_chk #(.OUT_W(OUT_W), .MAN_W(MAN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_bits    (out_bits),
  .out_illegal (out_illegal),
  .out_nx      (out_nx),
  .out_nv      (out_nv)
);

// File: tb/i2f_conv_bench.sv
module i2f_conv_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_int = '0;
  logic        in_signed = 1'b0;
  logic [2:0]  in_rm = '0;
  logic [2:0]  in_frm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_bits;
  logic        out_illegal;
  logic        out_nx;
  logic        out_nv;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  i2f_conv u_i2f_conv (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_int (in_int),
    .in_signed (in_signed), .in_rm (in_rm), .in_frm (in_frm),
    .out_valid (out_valid), .out_ready (out_ready), .out_bits (out_bits),
    .out_illegal (out_illegal), .out_nx (out_nx), .out_nv (out_nv)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference: {inexact, bits}, computed with wide integer division by powers of two.
  function automatic logic [32:0] ref_conv(logic [31:0] a, logic sgn, logic [2:0] md);
    logic        neg;
    logic [63:0] mag, q, rem, half;
    logic        inc, nx;
    int          p, sh;
    neg = sgn && a[31];
    mag = neg ? ((64'd1 << 32) - {32'd0, a}) : {32'd0, a};
    if (mag == 0) return 33'd0;
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    inc = 1'b0;
    rem = 0;
    if (p <= 23) begin
      q = mag << (23 - p);
    end else begin
      sh   = p - 23;
      q    = mag >> sh;
      rem  = mag - (q << sh);
      half = 64'd1 << (sh - 1);
      case (md)
        3'd0: inc = (rem > half) || (rem == half && q[0]);
        3'd2: inc = (rem != 0) && neg;
        3'd3: inc = (rem != 0) && !neg;
        3'd4: inc = (rem >= half);
        default: inc = 1'b0;
      endcase
    end
    nx = (rem != 0);
    q = q + 64'(inc);
    if (q[24]) begin
      q = q >> 1;
      p++;
    end
    return {nx, neg, 8'(p + 127), q[22:0]};
  endfunction

  // Called and returns at a falling edge, with the output stage empty.
  task automatic do_op(logic [31:0] a, logic sgn, logic [2:0] rm, logic [2:0] frm, int stall);
    logic        bad;
    logic [2:0]  md;
    logic [32:0] e;
    logic [31:0] held;
    string       tag;
    in_int = a; in_signed = sgn; in_rm = rm; in_frm = frm;
    in_valid = 1'b1;
    out_ready = (stall == 0);
    @(negedge clk);
    in_valid = 1'b0;
    bad = (rm == 3'd5) || (rm == 3'd6) || (rm == 3'd7 && frm >= 3'd5);
    md  = (rm == 3'd7) ? frm : rm;
    e   = bad ? 33'd0 : ref_conv(a, sgn, md);
    if (bad) tag = (rm == 3'd7) ? "R5" : "R4";
    else if (a == 0) tag = "R8";
    else if (sgn && a[31]) tag = "R6";
    else tag = "R3/R7";
    chk("R1 result valid", out_valid, 1);
    chk({tag, " illegal"}, out_illegal, bad);
    chk({tag, " bits"}, out_bits, e[31:0]);
    chk({tag, " R9 inexact"}, out_nx, e[32]);
    chk("R9 invalid", out_nv, 0);
    if (stall > 0) begin
      chk("R1 ready low under stall", in_ready, 0);
      held = out_bits;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R2 valid held", out_valid, 1);
        chk("R2 bits held", out_bits, held);
      end
      out_ready = 1'b1;
    end else begin
      chk("R1 ready high when draining", in_ready, 1);
    end
    @(negedge clk);
    chk("R1 drained", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] seed_v;
    logic [31:0] prev;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid after reset", out_valid, 0);
    chk("R10 ready after reset", in_ready, 1);

    // R8: zero in every legal mode, both interpretations
    for (int m = 0; m < 5; m++) begin
      do_op(32'd0, 1'b1, 3'(m), 3'd0, 0);
      do_op(32'd0, 1'b0, 3'd7, 3'(m), 0);
    end
    // R4 / R5: reserved codes, even on a zero operand
    do_op(32'd0, 1'b0, 3'd5, 3'd0, 0);
    do_op(32'd0, 1'b1, 3'd6, 3'd0, 1);
    do_op(32'h0100_0001, 1'b0, 3'd7, 3'd5, 0);
    do_op(32'd0, 1'b0, 3'd7, 3'd6, 0);
    do_op(32'hFFFF_FFFF, 1'b0, 3'd7, 3'd7, 2);
    // Extremes and ties in every mode (R3, R6, R7)
    for (int m = 0; m < 5; m++) begin
      do_op(32'h8000_0000, 1'b1, 3'(m), 3'd0, 0);
      do_op(32'h8000_0000, 1'b0, 3'(m), 3'd0, 0);
      do_op(32'hFFFF_FFFF, 1'b1, 3'(m), 3'd0, 0);
      do_op(32'hFFFF_FFFF, 1'b0, 3'(m), 3'd0, 1);
      do_op(32'h7FFF_FFFF, 1'b1, 3'd7, 3'(m), 0);
      do_op(32'h0100_0001, 1'b0, 3'(m), 3'd0, 0);
      do_op(32'h0100_0003, 1'b0, 3'(m), 3'd0, 0);
      do_op(32'hFEFF_FFFD, 1'b1, 3'(m), 3'd0, 0);
      do_op(32'h00FF_FFFF, 1'b0, 3'(m), 3'd0, 0);
    end
    // R3: deferred mode differs from the static field
    do_op(32'h0100_0001, 1'b0, 3'd7, 3'd3, 0);

    // R1: streaming, one operand per cycle
    out_ready = 1'b1;
    in_int = 32'd5; in_signed = 1'b0; in_rm = 3'd0; in_frm = 3'd0;
    in_valid = 1'b1;
    prev = 32'd5;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1 stream valid", out_valid, 1);
      chk("R1 stream ready", in_ready, 1);
      chk("R7 stream bits", out_bits, ref_conv(prev, 1'b0, 3'd0) & 33'h0_FFFF_FFFF);
      prev = prev + 32'd1000;
      in_int = prev;
    end
    in_valid = 1'b0;
    @(negedge clk);

    // Constrained random
    for (int n = 0; n < 2500; n++) begin
      logic [31:0] a;
      logic [2:0]  rm;
      case ($urandom % 4)
        0: a = $urandom;
        1: a = $urandom >> ($urandom % 32);
        2: a = 32'h1 << ($urandom % 32);
        default: a = ~($urandom >> ($urandom % 32));
      endcase
      rm = ($urandom % 8 == 0) ? 3'($urandom % 8) : 3'($urandom % 5);
      if ($urandom % 4 == 0) rm = 3'd7;
      do_op(a, 1'($urandom), rm, 3'($urandom % 8), int'($urandom % 3));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule